// File: doc/BRIEF.md
# Ternary Route Lookup Engine

This block turns a destination key into a router output port in one pipelined lookup. It holds a small table of rows. Each row keeps one key pattern and a per-bit care mask, and beside the table sits a port memory with one output-port entry per row. A search key is compared against every row at once. Each row drives a matchline, and a fixed-priority encoder turns the asserted matchlines into a row index. That index then addresses the port memory, which supplies the forwarding port.

Software or a control plane fills the table through a single row-write port. One write carries the pattern, the mask and the port, so a row is installed or replaced as a unit. Search requests may be issued every cycle. Each one yields exactly one result, two cycles later, carrying a hit flag and a port.

Top module: `tcam_lookup`

## Requirements
- R1: After reset, resValid, resHit are 0 and resPort equals DEFAULT_PORT (default 15). Every row is empty, so a search of any key misses.
- R2: In wrCare, bit value 1 means the key bit must equal the stored bit, and value 0 means that bit matches either key value.
- R3: When a search key matches a written row, the result has resHit=1 and resPort equal to the port last written for that row.
- R4: When several rows match, the result uses the lowest-numbered matching row.
- R5: When no written row matches, the result has resHit=0 and resPort=DEFAULT_PORT.
- R6: A search accepted on a clock edge (srchValid=1) produces resValid=1 exactly two edges later. Searches on consecutive cycles give results on consecutive cycles, in order.
- R7: A row write in the same cycle as a search is not seen by that search: the pattern, mask and port used are the old ones. A search in the next cycle sees the new row.
- R8: Writing a row that already holds an entry replaces its pattern, mask and port together.
- R9: In any cycle with resValid=0, resHit is 0 and resPort equals DEFAULT_PORT.
- R10: A row that has never been written never matches, whatever the key.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Row write strobe |
| wrRow | input | IDX_W (3) | Row index to write |
| wrWord | input | KEY_W (8) | Stored key pattern |
| wrCare | input | KEY_W (8) | Care mask, 1 = compare this bit, 0 = don't care |
| wrPort | input | PORT_W (4) | Output port for the row |
| srchValid | input | 1 | Search request strobe |
| srchKey | input | KEY_W (8) | Destination key to look up |
| resValid | output | 1 | Result valid, two cycles after the request |
| resHit | output | 1 | A row matched |
| resPort | output | PORT_W (4) | Forwarding port, DEFAULT_PORT on miss |

## Verification
A corrupted pattern or mask bit appears as a wrong hit flag or wrong port on the very next lookup that touches that row. The bench therefore sweeps keys that differ only in cared and don't-care positions. A broken priority encoder or port memory shows up as the port of the wrong row, and the first lookup hitting overlapping rows exposes it. Valid-pipeline or write-ordering faults shift results by a cycle. The scoreboard catches them at once, because it ties each result to the cycle in which it is due and to the table contents as they stood when the search was issued.

// File: rtl/tcam_lookup_pkg.sv
package tcam_lookup_pkg;
  typedef struct packed {
    logic tagWr;    // update pattern/mask/valid of a row
    logic portWr;   // commit the pending port memory write
    logic cmpLoad;  // capture compare + encode result
    logic rdLoad;   // capture port memory read
  } ctrlStrobes_t;
endpackage

// File: rtl/tcam_lookup_ctrl.sv
module tcam_lookup_ctrl
  import tcam_lookup_pkg::*;
(
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wrEn,
  input  logic         srchValid,
  output ctrlStrobes_t strobes,
  output logic         resValid
);
  logic portWrPend;
  logic s1Valid;
  logic s2Valid;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      portWrPend <= 1'b0;
      s1Valid    <= 1'b0;
      s2Valid    <= 1'b0;
    end else begin
      portWrPend <= wrEn;
      s1Valid    <= srchValid;
      s2Valid    <= s1Valid;
    end
  end

  always_comb begin
    strobes.tagWr   = wrEn;
    strobes.portWr  = portWrPend;
    strobes.cmpLoad = srchValid;
    strobes.rdLoad  = s1Valid;
  end

  assign resValid = s2Valid;

  // R6
  srch_to_stage1_chk: assert property (@(posedge clk) disable iff (!rst_n)
    srchValid |=> s1Valid);
  // R6
  stage1_to_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
    s1Valid |=> resValid);
  // R7
  port_commit_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wrEn |=> strobes.portWr);
endmodule

// File: rtl/tcam_lookup_dp.sv
module tcam_lookup_dp
  import tcam_lookup_pkg::*;
#(
  parameter int KEY_W        = 8,
  parameter int ROWS         = 8,
  parameter int PORT_W       = 4,
  parameter int DEFAULT_PORT = 15,
  localparam int IDX_W       = (ROWS > 1) ? $clog2(ROWS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  ctrlStrobes_t      strobes,
  input  logic [IDX_W-1:0]  wrRow,
  input  logic [KEY_W-1:0]  wrWord,
  input  logic [KEY_W-1:0]  wrCare,
  input  logic [PORT_W-1:0] wrPort,
  input  logic [KEY_W-1:0]  srchKey,
  output logic              resHit,
  output logic [PORT_W-1:0] resPort
);
  localparam logic [PORT_W-1:0] DefPort = PORT_W'(DEFAULT_PORT);

  logic [KEY_W-1:0]  rowWord [ROWS];
  logic [KEY_W-1:0]  rowCare [ROWS];
  logic [ROWS-1:0]   rowValid;
  logic [PORT_W-1:0] portMem [ROWS];
  logic [IDX_W-1:0]  pendRow;
  logic [PORT_W-1:0] pendPort;
  logic [ROWS-1:0]   matchLine;
  logic              encHit;
  logic [IDX_W-1:0]  encIdx;
  logic              s1Hit;
  logic [IDX_W-1:0]  s1Idx;

  // table storage: pattern and mask, no reset needed
  always_ff @(posedge clk) begin
    if (strobes.tagWr && (int'(wrRow) < ROWS)) begin
      rowWord[wrRow] <= wrWord;
      rowCare[wrRow] <= wrCare;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rowValid <= '0;
    end else if (strobes.tagWr && (int'(wrRow) < ROWS)) begin
      rowValid[wrRow] <= 1'b1;
    end
  end

  // port write is held one cycle so an in-flight search reads the old port
  always_ff @(posedge clk) begin
    if (strobes.tagWr) begin
      pendRow  <= wrRow;
      pendPort <= wrPort;
    end
    if (strobes.portWr && (int'(pendRow) < ROWS)) begin
      portMem[pendRow] <= pendPort;
    end
  end

  // per-row ternary compare
  for (genvar g = 0; g < ROWS; g++) begin : g_row
    assign matchLine[g] = rowValid[g] &&
                          (((srchKey ^ rowWord[g]) & rowCare[g]) == '0);
  end

  // fixed priority encoder, lowest row wins
  always_comb begin
    encHit = |matchLine;
    encIdx = '0;
    for (int i = ROWS - 1; i >= 0; i--) begin
      if (matchLine[i]) encIdx = IDX_W'(i);
    end
  end

  // stage 1: compare and encode
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1Hit <= 1'b0;
      s1Idx <= '0;
    end else if (strobes.cmpLoad) begin
      s1Hit <= encHit;
      s1Idx <= encIdx;
    end else begin
      s1Hit <= 1'b0;
    end
  end

  // stage 2: port memory read
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      resHit  <= 1'b0;
      resPort <= DefPort;
    end else if (strobes.rdLoad && s1Hit) begin
      resHit  <= 1'b1;
      resPort <= portMem[s1Idx];
    end else begin
      resHit  <= 1'b0;
      resPort <= DefPort;
    end
  end

  // R10
  hit_row_written_chk: assert property (@(posedge clk) disable iff (!rst_n)
    s1Hit |-> rowValid[s1Idx]);
  // R4
  row0_priority_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (strobes.cmpLoad && matchLine[0]) |=> (s1Hit && s1Idx == '0));
  // R9
  hit_needs_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    resHit |-> $past(strobes.rdLoad));
endmodule

// File: rtl/tcam_lookup.sv
module tcam_lookup
  import tcam_lookup_pkg::*;
#(
  parameter int KEY_W        = 8,
  parameter int ROWS         = 8,
  parameter int PORT_W       = 4,
  parameter int DEFAULT_PORT = 15,
  localparam int IDX_W       = (ROWS > 1) ? $clog2(ROWS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wrEn,
  input  logic [IDX_W-1:0]  wrRow,
  input  logic [KEY_W-1:0]  wrWord,
  input  logic [KEY_W-1:0]  wrCare,
  input  logic [PORT_W-1:0] wrPort,
  input  logic              srchValid,
  input  logic [KEY_W-1:0]  srchKey,
  output logic              resValid,
  output logic              resHit,
  output logic [PORT_W-1:0] resPort
);
  ctrlStrobes_t strobes;

  tcam_lookup_ctrl ctrl_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .wrEn      (wrEn),
    .srchValid (srchValid),
    .strobes   (strobes),
    .resValid  (resValid)
  );

  tcam_lookup_dp #(
    .KEY_W        (KEY_W),
    .ROWS         (ROWS),
    .PORT_W       (PORT_W),
    .DEFAULT_PORT (DEFAULT_PORT)
  ) dp_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .strobes (strobes),
    .wrRow   (wrRow),
    .wrWord  (wrWord),
    .wrCare  (wrCare),
    .wrPort  (wrPort),
    .srchKey (srchKey),
    .resHit  (resHit),
    .resPort (resPort)
  );
endmodule

// File: tb/tcam_lookup_tb_top.sv
module tcam_lookup_tb_top;
  localparam int KEY_W = 8;
  localparam int ROWS = 8;
  localparam int PORT_W = 4;
  localparam int DEFP = 15;

  typedef struct {
    logic              hit;
    logic [PORT_W-1:0] port;
    int                dueCyc;
    string             req;
  } expItem_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wrEn = 1'b0;
  logic [2:0] wrRow = '0;
  logic [KEY_W-1:0] wrWord = '0;
  logic [KEY_W-1:0] wrCare = '0;
  logic [PORT_W-1:0] wrPort = '0;
  logic srchValid = 1'b0;
  logic [KEY_W-1:0] srchKey = '0;
  logic resValid;
  logic resHit;
  logic [PORT_W-1:0] resPort;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit done = 1'b0;

  expItem_t scbQ[$];
  logic [KEY_W-1:0]  mWord [ROWS];
  logic [KEY_W-1:0]  mCare [ROWS];
  logic [PORT_W-1:0] mPort [ROWS];
  bit                mUsed [ROWS];

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  tcam_lookup dut_i (
    .clk(clk), .rst_n(rst_n), .wrEn(wrEn), .wrRow(wrRow), .wrWord(wrWord),
    .wrCare(wrCare), .wrPort(wrPort), .srchValid(srchValid), .srchKey(srchKey),
    .resValid(resValid), .resHit(resHit), .resPort(resPort)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic expItem_t predict(input logic [KEY_W-1:0] key,
                                       input int due, input string req);
    expItem_t e;
    e.hit = 1'b0;
    e.port = PORT_W'(DEFP);
    e.dueCyc = due;
    e.req = req;
    for (int i = ROWS - 1; i >= 0; i--) begin
      if (mUsed[i] && (((key ^ mWord[i]) & mCare[i]) == '0)) begin
        e.hit = 1'b1;
        e.port = mPort[i];
      end
    end
    return e;
  endfunction

  // driver: one cycle of stimulus, expectation taken from old contents
  task automatic step(input bit s, input logic [KEY_W-1:0] key, input bit w,
                      input int row, input logic [KEY_W-1:0] word,
                      input logic [KEY_W-1:0] care, input logic [PORT_W-1:0] port,
                      input string req);
    @(negedge clk);
    srchValid = s;
    srchKey = key;
    wrEn = w;
    wrRow = 3'(row);
    wrWord = word;
    wrCare = care;
    wrPort = port;
    if (s) scbQ.push_back(predict(key, cyc + 2, req));
    if (w) begin
      mWord[row] = word;
      mCare[row] = care;
      mPort[row] = port;
      mUsed[row] = 1'b1;
    end
  endtask

  task automatic srch(input logic [KEY_W-1:0] key, input string req);
    step(1'b1, key, 1'b0, 0, '0, '0, '0, req);
  endtask

  task automatic wr(input int row, input logic [KEY_W-1:0] word,
                    input logic [KEY_W-1:0] care, input logic [PORT_W-1:0] port);
    step(1'b0, '0, 1'b1, row, word, care, port, "");
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(1'b0, '0, 1'b0, 0, '0, '0, '0, "");
  endtask

  // monitor
  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (resValid) begin
        if (scbQ.size() == 0) begin
          chk(1'b0, "R6", "unexpected result", 1, 0);
        end else begin
          expItem_t e;
          e = scbQ.pop_front();
          chk(e.dueCyc == cyc, "R6", "result cycle", cyc, e.dueCyc);
          chk(resHit == e.hit, e.req, "hit", int'(resHit), int'(e.hit));
          chk(resPort == e.port, e.req, "port", int'(resPort), int'(e.port));
        end
      end else begin
        chk(resHit == 1'b0 && resPort == PORT_W'(DEFP), "R9", "idle outputs",
            int'(resPort) + 16 * int'(resHit), DEFP);
      end
    end
  end

  initial begin
    for (int i = 0; i < ROWS; i++) begin
      mUsed[i] = 1'b0;
      mWord[i] = '0;
      mCare[i] = '0;
      mPort[i] = '0;
    end
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(resValid == 1'b0, "R1", "resValid in reset", int'(resValid), 0);
    chk(resHit == 1'b0, "R1", "resHit in reset", int'(resHit), 0);
    chk(resPort == PORT_W'(DEFP), "R1", "resPort in reset", int'(resPort), DEFP);
    rst_n = 1'b1;
    // R1 / R10: empty table misses even an all-zero key
    srch(8'h00, "R10");
    srch(8'hFF, "R1");
    // R2: row 2 holds xxxxx011
    wr(2, 8'h03, 8'h07, 4'd5);
    srch(8'hF3, "R2");
    srch(8'h0B, "R2");
    srch(8'h07, "R2");
    srch(8'h02, "R5");
    // R4: row 5 exact 0x03 overlaps row 2, row 2 wins
    wr(5, 8'h03, 8'hFF, 4'd9);
    srch(8'h03, "R4");
    // row 0 all don't-care now beats everything
    wr(0, 8'h00, 8'h00, 4'd1);
    srch(8'h03, "R4");
    srch(8'h5A, "R3");
    // R8: rewrite row 0 as exact 0xAA with port 12
    wr(0, 8'hAA, 8'hFF, 4'd12);
    srch(8'h03, "R8");
    srch(8'hAA, "R8");
    srch(8'h5A, "R5");
    // R7: write row 1 in the same cycle as a search of its key
    step(1'b1, 8'h55, 1'b1, 1, 8'h55, 8'hFF, 4'd7, "R7");
    srch(8'h55, "R7");
    // R7: same-cycle port change of row 2 keeps old port
    step(1'b1, 8'h03, 1'b1, 2, 8'h03, 8'h07, 4'd3, "R7");
    srch(8'h03, "R7");
    // R6: back-to-back mixed searches
    srch(8'hAA, "R6");
    srch(8'h13, "R6");
    srch(8'h00, "R6");
    srch(8'h55, "R6");
    idle(1);
    srch(8'hAB, "R5");
    idle(5);
    chk(scbQ.size() == 0, "R6", "pending results", scbQ.size(), 0);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule